// File: doc/BRIEF.md
# Error-Tolerant Frame Sync Detector

This block watches a recovered serial bit stream, one bit per strobe, and raises a pulse when the most recent 16 bits match a programmed synchronization word. A tolerance switch lets the comparison accept a window that differs from the word in at most one bit position. In that mode 17 of the 65536 possible windows are accepted.

Random data can satisfy a short word, especially when one error is allowed. To guard against this, an optional second stage takes the 16 bits that follow a detection and compares them exactly with a further expected pattern. Only a full match of that pattern yields a confirmation pulse. A mismatch sends the block back to searching with an empty window. The host should enable the block shortly before the sync word is due, so that noise has little time to produce a false hit.

Top module: `fsync_hunter`

## Requirements
- R1: After reset both outputs are low. No detection is possible until 16 strobed bits have entered the window since reset.
- R2: With tolerance off, a detection happens only when the last 16 strobed bits equal `sync_word` exactly. The earliest of those bits is compared with bit 15 and the latest with bit 0.
- R3: With tolerance on, a window that differs from `sync_word` in exactly one position is accepted. A window that differs in two or more positions is rejected.
- R4: `det_o` is a single-cycle pulse. It is high in the cycle that follows the clock edge that sampled the strobe of the last window bit.
- R5: With the extended check off at detection time, `conf_o` pulses in the same cycle as `det_o`.
- R6: With the extended check on, the next 16 strobed bits after a detection are compared exactly with `ext_word`, earliest bit to bit 15, regardless of `tol_en`. On a full match `conf_o` pulses in the cycle after the edge that sampled the 16th of those bits. On any mismatch `conf_o` stays low.
- R7: While the extension bits are being collected, the search is suspended and `det_o` stays low, even if those bits contain the sync word.
- R8: After every detection the window is emptied. The next detection needs 16 newly strobed bits, so bits from the earlier match cannot trigger it again.
- R9: Values on `bit_in` in cycles where `bit_valid` is low are ignored. They do not enter the window or the extension comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe marking a valid received bit |
| bit_in | input | 1 | Received data bit |
| sync_word | input | 16 | Programmed synchronization word |
| ext_word | input | 16 | Expected bits that follow the sync word |
| tol_en | input | 1 | Accept one mismatched bit in the sync word |
| ext_en | input | 1 | Enable the second-stage extension check |
| det_o | output | 1 | Sync word detected pulse |
| conf_o | output | 1 | Sync confirmed pulse |

## Verification
Detection and confirmation fall in the same cycle whenever the extended check is off. The bench provokes this by sending the sync word with `ext_en` low and expects both pulses on the same clock. With the check on, the bench sends the sync word as the extension bits and expects a lone detection followed by silence on both outputs, which shows the two functions separating. A behavioural model built on bit queues predicts both outputs every clock, including the window emptying after each hit and the effect of strobe gaps.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    localparam int unsigned POP_MAXW = 32;

    typedef enum logic [0:0] {
        ST_HUNT  = 1'b0,
        ST_CHECK = 1'b1
    } fsh_state_e;

    typedef struct packed {
        logic det;
        logic conf;
    } fsh_evt_t;

    function automatic logic [5:0] popcnt(input logic [POP_MAXW-1:0] v);
        logic [5:0] n;
        n = '0;
        for (int i = 0; i < POP_MAXW; i++) begin
            n = n + {5'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/fsh_window.sv
module fsh_window #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         clr,
    input  logic         bit_in,
    output logic [W-1:0] win_nxt,
    output logic         full_nxt
);
    localparam int unsigned CW = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    logic [W-1:0]  sr;
    logic [CW-1:0] fill;
    logic [CW-1:0] fill_inc;

    always_comb begin
        win_nxt  = {sr[W-2:0], bit_in};
        fill_inc = (fill == FULL) ? fill : fill + 1'b1;
        full_nxt = shift_en && (fill_inc == FULL);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr   <= '0;
            fill <= '0;
        end else if (shift_en) begin
            sr   <= win_nxt;
            fill <= fill_inc;
        end
    end

    // R8
    window_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (fill == '0));

    // R9
    window_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(shift_en) && !$past(clr) && !$past(rst)) |-> $stable(fill));

endmodule

// File: rtl/fsh_match.sv
module fsh_match #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] win,
    input  logic [W-1:0] sync_word,
    input  logic         tol_en,
    output logic         hit
);
    import fsh_pkg::*;

    logic [5:0] mism;

    always_comb begin
        mism = popcnt(POP_MAXW'(win ^ sync_word));
        hit  = tol_en ? (mism <= 6'd1) : (mism == 6'd0);
    end

endmodule

// File: rtl/fsh_ctrl.sv
module fsh_ctrl #(
    parameter int unsigned EW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_valid,
    input  logic          bit_in,
    input  logic [EW-1:0] ext_word,
    input  logic          ext_en,
    input  logic          hit,
    input  logic          full_nxt,
    output logic          shift_en,
    output logic          win_clr,
    output logic          det_o,
    output logic          conf_o
);
    import fsh_pkg::*;

    localparam int unsigned CW = $clog2(EW + 1);
    localparam logic [CW-1:0] LAST = CW'(EW - 1);

    fsh_state_e    state;
    logic [EW-1:0] ext_sr;
    logic [EW-1:0] ext_nxt;
    logic [CW-1:0] ext_cnt;
    logic          found;
    logic          ext_take;
    logic          ext_last;
    fsh_evt_t      evt;

    always_comb begin
        shift_en = bit_valid && (state == ST_HUNT);
        found    = shift_en && full_nxt && hit;
        win_clr  = found;
        ext_take = bit_valid && (state == ST_CHECK);
        ext_last = ext_take && (ext_cnt == LAST);
        ext_nxt  = {ext_sr[EW-2:0], bit_in};
        evt.det  = found;
        evt.conf = (found && !ext_en) || (ext_last && (ext_nxt == ext_word));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HUNT;
            ext_sr  <= '0;
            ext_cnt <= '0;
            det_o   <= 1'b0;
            conf_o  <= 1'b0;
        end else begin
            det_o  <= evt.det;
            conf_o <= evt.conf;
            case (state)
                ST_HUNT: begin
                    if (found && ext_en) begin
                        state   <= ST_CHECK;
                        ext_cnt <= '0;
                        ext_sr  <= '0;
                    end
                end
                ST_CHECK: begin
                    if (ext_take) begin
                        ext_sr  <= ext_nxt;
                        ext_cnt <= ext_cnt + 1'b1;
                        if (ext_last) begin
                            state <= ST_HUNT;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // R4
    det_single_chk: assert property (@(posedge clk) disable iff (rst)
        det_o |=> !det_o);

    // R4
    det_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        det_o |-> $past(bit_valid));

    // R7
    no_det_in_check_chk: assert property (@(posedge clk) disable iff (rst)
        det_o |-> ($past(state) == ST_HUNT));

    // R5
    conf_with_det_chk: assert property (@(posedge clk) disable iff (rst)
        (det_o && !$past(ext_en)) |-> conf_o);

    // R6
    conf_from_check_chk: assert property (@(posedge clk) disable iff (rst)
        (conf_o && !det_o) |-> ($past(state) == ST_CHECK && $past(bit_valid)));

endmodule

// File: rtl/fsync_hunter.sv
module fsync_hunter #(
    parameter int unsigned SYNC_W = 16,
    parameter int unsigned EXT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [EXT_W-1:0]  ext_word,
    input  logic              tol_en,
    input  logic              ext_en,
    output logic              det_o,
    output logic              conf_o
);
    logic [SYNC_W-1:0] win_nxt;
    logic              full_nxt;
    logic              shift_en;
    logic              win_clr;
    logic              hit;

    fsh_window #(.W(SYNC_W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .clr      (win_clr),
        .bit_in   (bit_in),
        .win_nxt  (win_nxt),
        .full_nxt (full_nxt)
    );

    fsh_match #(.W(SYNC_W)) u_match (
        .win       (win_nxt),
        .sync_word (sync_word),
        .tol_en    (tol_en),
        .hit       (hit)
    );

    fsh_ctrl #(.EW(EXT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .ext_word  (ext_word),
        .ext_en    (ext_en),
        .hit       (hit),
        .full_nxt  (full_nxt),
        .shift_en  (shift_en),
        .win_clr   (win_clr),
        .det_o     (det_o),
        .conf_o    (conf_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!det_o && !conf_o));

endmodule

// File: tb/fsync_hunter_tb.sv
module fsync_hunter_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic [15:0] sync_word = 16'hB433;
    logic [15:0] ext_word = 16'h5A0F;
    logic        tol_en = 1'b0;
    logic        ext_en = 1'b0;
    logic        det_o;
    logic        conf_o;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";

    bit        q[$];
    int        mode = 0;
    int        ext_n = 0;
    logic [15:0] ev = '0;
    logic      exp_det = 1'b0;
    logic      exp_conf = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int        det_seen = 0;
    int        conf_seen = 0;

    always #(CLK_P/2) clk = ~clk;

    fsync_hunter u_dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .sync_word(sync_word), .ext_word(ext_word), .tol_en(tol_en),
        .ext_en(ext_en), .det_o(det_o), .conf_o(conf_o)
    );

    task automatic model(input logic v, input logic b);
        exp_det = 1'b0;
        exp_conf = 1'b0;
        if (!v) return;
        if (mode == 0) begin
            q.push_back(b);
            if (q.size() > 16) void'(q.pop_front());
            if (q.size() == 16) begin
                int mism = 0;
                for (int i = 0; i < 16; i++) if (q[i] != sync_word[15-i]) mism++;
                if (mism <= (tol_en ? 1 : 0)) begin
                    exp_det = 1'b1;
                    q.delete();
                    if (ext_en) begin
                        mode = 1;
                        ext_n = 0;
                        ev = '0;
                    end else begin
                        exp_conf = 1'b1;
                    end
                end
            end
        end else begin
            ev = {ev[14:0], b};
            ext_n++;
            if (ext_n == 16) begin
                exp_conf = (ev == ext_word);
                mode = 0;
            end
        end
    endtask

    task automatic compare();
        n_chk++;
        if (det_o !== exp_det) begin
            n_bad++;
            $display("FAIL %s det_o actual=%b expected=%b t=%0t", tag, det_o, exp_det, $time);
        end
        n_chk++;
        if (conf_o !== exp_conf) begin
            n_bad++;
            $display("FAIL %s conf_o actual=%b expected=%b t=%0t", tag, conf_o, exp_conf, $time);
        end
        if (det_o === 1'b1) det_seen++;
        if (conf_o === 1'b1) conf_seen++;
    endtask

    task automatic step(input logic v, input logic b);
        @(negedge clk);
        bit_valid = v;
        bit_in = b;
        model(v, b);
        @(posedge clk);
        #(CLK_P/4);
        compare();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        mode = 0;
        exp_det = 1'b0;
        exp_conf = 1'b0;
        @(posedge clk);
        #(CLK_P/4);
        compare();
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) step(1'b1, w[i]);
    endtask

    task automatic noise(input int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b1, lfsr[0]);
        end
    endtask

    task automatic expect_count(input string t, input int got, input int want);
        n_chk++;
        if (got != want) begin
            n_bad++;
            $display("FAIL %s pulse count actual=%0d expected=%0d", t, got, want);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state and no early hit with an all-zero word
        tag = "R1";
        sync_word = 16'h0000;
        do_reset();
        det_seen = 0;
        for (int i = 0; i < 15; i++) step(1'b1, 1'b0);
        expect_count("R1", det_seen, 0);
        step(1'b1, 1'b0);
        expect_count("R1", det_seen, 1);

        // R2 / R5: exact detection, confirm coincides with detect
        tag = "R2";
        sync_word = 16'hB433;
        do_reset();
        noise(23);
        det_seen = 0; conf_seen = 0;
        send_word(16'hB433);
        expect_count("R2", det_seen, 1);
        tag = "R5";
        expect_count("R5", conf_seen, 1);

        // R2: one-bit error rejected when tolerance off
        tag = "R2";
        det_seen = 0;
        send_word(16'hB433 ^ 16'h0100);
        expect_count("R2", det_seen, 0);

        // R3: one-bit error accepted, two-bit error rejected
        tag = "R3";
        tol_en = 1'b1;
        do_reset();
        det_seen = 0;
        send_word(16'hB433 ^ 16'h8000);
        expect_count("R3", det_seen, 1);
        det_seen = 0;
        send_word(16'hB433 ^ 16'h0011);
        expect_count("R3", det_seen, 0);
        tol_en = 1'b0;

        // R9: strobe gaps with junk on the data line
        tag = "R9";
        do_reset();
        det_seen = 0;
        for (int i = 15; i >= 0; i--) begin
            step(1'b0, ~sync_word[i]);
            step(1'b1, sync_word[i]);
            step(1'b0, 1'b1);
        end
        expect_count("R9", det_seen, 1);

        // R8: all-ones word, window emptied after each hit
        tag = "R8";
        sync_word = 16'hFFFF;
        do_reset();
        det_seen = 0;
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1);
        expect_count("R8", det_seen, 1);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1);
        expect_count("R8", det_seen, 2);

        // R6: extension matches, confirm after extension bits
        tag = "R6";
        sync_word = 16'hB433;
        ext_en = 1'b1;
        do_reset();
        det_seen = 0; conf_seen = 0;
        send_word(16'hB433);
        expect_count("R6", conf_seen, 0);
        send_word(16'h5A0F);
        expect_count("R6", det_seen, 1);
        expect_count("R6", conf_seen, 1);

        // R6: one-bit error in extension rejected even with tolerance on
        tol_en = 1'b1;
        conf_seen = 0;
        send_word(16'hB433);
        send_word(16'h5A0F ^ 16'h0004);
        expect_count("R6", conf_seen, 0);
        tol_en = 1'b0;

        // R7: sync word inside the extension window does not detect
        tag = "R7";
        det_seen = 0; conf_seen = 0;
        send_word(16'hB433);
        send_word(16'hB433);
        expect_count("R7", det_seen, 1);
        expect_count("R7", conf_seen, 0);
        send_word(16'hB433);
        send_word(16'h5A0F);
        expect_count("R7", conf_seen, 1);

        // R4: mixed noise and words, model compared every clock
        tag = "R4";
        ext_en = 1'b0;
        tol_en = 1'b1;
        noise(400);
        ext_en = 1'b1;
        noise(400);
        tol_en = 1'b0;
        ext_en = 1'b0;
        send_word(16'hB433);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule